// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects up to 128 level-sensitive interrupt sources, organised in banks of 32, and reduces them to two active-low request lines to a processor. One line is for normal interrupts (IRQ) and one is for fast interrupts (FIQ). Each source has its own level word, which sets a 6-bit priority and routes the source to one of the two lines. Each bank has a mask, set and clear aliases for that mask, and a software trigger that raises a source as though its input pin were high.

For each line, the controller finds the most urgent unmasked pending source. It captures that source's number when the line is armed and holds it in a read-only active-source register. Software reads the number, services the source, and then writes an acknowledge bit. That write re-arms capture for the line.

Register accesses are single-cycle and happen on a plain 32-bit register port. There is no back-pressure: a write takes effect at the clock edge where `reg_sel_i` and `reg_we_i` are both high. Read data is combinational from `reg_addr_i` and has no side effects. `NUM_SRC` must be a multiple of 32 and no larger than 128.

Top module: `pic_top`

## Requirements
- R1: After reset, every mask bit is 1, every level word and software trigger is 0, and both `irq_no` and `fiq_no` are high. The revision word at 0x000 reads 0x10 (major number in bits [7:4], minor number in bits [3:0]). The ready bit (bit 0 at 0x014) reads 1 from the first clock edge after reset is released.
- R2: Source n lives in bank n[6:5] at bit n[4:0]. Bank b's registers start at 0x080 + 0x20·b. The word at +0x00 shows each source's input pin ORed with its software trigger.
- R3: The mask at +0x04 is read/write, and a 1 blocks the source. Writing 1s at +0x0C sets mask bits and writing 1s at +0x08 clears them. Zero bits in either alias leave the mask unchanged, and both aliases read back the mask.
- R4: Writing 1s at +0x10 sets software triggers and writing 1s at +0x14 clears them. A set trigger acts like a high input until it is cleared, and both addresses read back the trigger word.
- R5: A source is pending when its input or its trigger is 1 and its mask bit is 0. A pending source routed to IRQ shows at +0x18; one routed to FIQ shows at +0x1C.
- R6: `irq_no` is low exactly while some IRQ-routed source is pending. `fiq_no` behaves the same way for FIQ-routed sources.
- R7: The level word for source n is at 0x100 + 4·n. Bit 0 is 1 for FIQ and 0 for IRQ, bits [7:2] hold the priority, and all other bits read 0.
- R8: Within a line, the pending source with the numerically lowest priority value wins. On a tie, the lower source number wins.
- R9: A line is armed after reset or after an acknowledge. At the first edge on which it is armed and has a pending source, it captures the winner and stops being armed. The active word (0x040 for IRQ, 0x044 for FIQ) then reads the number in bits [6:0] with bit 7 clear. The number holds even if the inputs change. While the line is armed, the active word reads 0x80.
- R10: Writing the control word at 0x048 re-arms lines at the next edge: bit 0 re-arms IRQ and bit 1 re-arms FIQ. The two lines are acknowledged independently.
- R11: Writing bit 1 of the configuration word at 0x010 is a soft reset. It restores the R1 state of masks, level words, triggers, both lines and the idle bit. The ready bit reads 0 in the following cycle and 1 one edge later, and configuration bit 1 always reads 0.
- R12: Configuration bit 0 (auto-idle) and bit 0 of the protection word at 0x04C are stored and read back, and have no other effect.
- R13: Writes to the revision, input, pending and active addresses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_sel_i | input | 1 | Register access select |
| reg_we_i | input | 1 | Write enable, qualified by select |
| reg_addr_i | input | 12 | Byte address, word aligned |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| src_i | input | NUM_SRC | Level-sensitive source inputs |
| irq_no | output | 1 | Normal interrupt request, active low |
| fiq_no | output | 1 | Fast interrupt request, active low |

## Verification
Two things can happen in the same cycle: an acknowledge write re-arms a line, and the source inputs change to a pattern with a different winner. The bench drives a new input pattern in the same cycle as the acknowledge. One cycle later it reads the active word, and the number must match the bench's arithmetic priority model applied to the new pattern, with no value left over from the old one. The line that was not acknowledged must still show its earlier capture.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int PRIO_W = 6;
  localparam int WORD_W = 32;

  localparam logic [11:0] A_REV      = 12'h000;
  localparam logic [11:0] A_SYSCFG   = 12'h010;
  localparam logic [11:0] A_SYSSTAT  = 12'h014;
  localparam logic [11:0] A_ACT_IRQ  = 12'h040;
  localparam logic [11:0] A_ACT_FIQ  = 12'h044;
  localparam logic [11:0] A_CTRL     = 12'h048;
  localparam logic [11:0] A_PROT     = 12'h04C;
  localparam logic [11:0] A_LVL_BASE = 12'h100;

  localparam logic [WORD_W-1:0] NONE_WORD = 32'h0000_0080;

  // word offset inside one bank window, bits [4:2] of the address
  typedef enum logic [2:0] {
    BR_RAW  = 3'd0,
    BR_MASK = 3'd1,
    BR_MCLR = 3'd2,
    BR_MSET = 3'd3,
    BR_SSET = 3'd4,
    BR_SCLR = 3'd5,
    BR_PIRQ = 3'd6,
    BR_PFIQ = 3'd7
  } bank_reg_e;

  typedef struct packed {
    logic [PRIO_W-1:0] prio;
    logic              fiq;
  } lvl_t;
endpackage

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
  parameter int N  = 128,
  parameter int PW = 6,
  parameter int IW = 7
) (
  input  logic [N-1:0]         pend_i,
  input  logic [N-1:0][PW-1:0] prio_i,
  output logic [IW-1:0]        win_o,
  output logic                 any_o
);
  logic [PW-1:0] best;

  // ascending scan, strict compare: ties keep the lower index
  always_comb begin
    best  = '1;
    win_o = '0;
    any_o = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (pend_i[i] && (!any_o || (prio_i[i] < best))) begin
        any_o = 1'b1;
        best  = prio_i[i];
        win_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/pic_bank.sv
module pic_bank #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         wr_mask_i,
  input  logic         wr_mclr_i,
  input  logic         wr_mset_i,
  input  logic         wr_sset_i,
  input  logic         wr_sclr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] swt_o
);
  logic [W-1:0] mask_q, swt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
      swt_q  <= '0;
    end else if (clr_i) begin
      mask_q <= '1;
      swt_q  <= '0;
    end else begin
      if (wr_mask_i)      mask_q <= wdata_i;
      else if (wr_mclr_i) mask_q <= mask_q & ~wdata_i;
      else if (wr_mset_i) mask_q <= mask_q | wdata_i;
      if (wr_sset_i)      swt_q  <= swt_q | wdata_i;
      else if (wr_sclr_i) swt_q  <= swt_q & ~wdata_i;
    end
  end

  assign mask_o = mask_q;
  assign swt_o  = swt_q;

  // R11
  bank_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (mask_q == '1 && swt_q == '0));
  // R4
  trig_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_sset_i && !clr_i) |=> ((swt_q & $past(wdata_i)) == $past(wdata_i)));
  // R3
  mask_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_mclr_i && !clr_i && !wr_mask_i) |=> ((mask_q & $past(wdata_i)) == '0));
endmodule

// File: rtl/pic_channel.sv
module pic_channel #(
  parameter int N  = 128,
  parameter int PW = 6,
  parameter int IW = 7
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 ack_i,
  input  logic [N-1:0]         pend_i,
  input  logic [N-1:0][PW-1:0] prio_i,
  output logic [IW-1:0]        num_o,
  output logic                 valid_o
);
  logic [IW-1:0] win;
  logic          any;
  logic [IW-1:0] num_q;
  logic          valid_q;

  pic_arbiter #(.N(N), .PW(PW), .IW(IW)) u_arb (
    .pend_i (pend_i),
    .prio_i (prio_i),
    .win_o  (win),
    .any_o  (any)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      num_q   <= '0;
    end else if (clr_i) begin
      valid_q <= 1'b0;
      num_q   <= '0;
    end else if (ack_i) begin
      valid_q <= 1'b0;
    end else if (!valid_q && any) begin
      valid_q <= 1'b1;
      num_q   <= win;
    end
  end

  assign num_o   = num_q;
  assign valid_o = valid_q;

  // R9
  hold_num_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !ack_i && !clr_i) |=> (valid_q && $stable(num_q)));
  // R10
  ack_rearm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> !valid_q);
  // R8
  win_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any |-> pend_i[win]);
  // R9
  capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_q && any && !ack_i && !clr_i) |=> valid_q);
endmodule

// File: rtl/pic_top.sv
module pic_top
  import pic_pkg::*;
#(
  parameter int          NUM_SRC   = 128,
  parameter logic [3:0]  REV_MAJOR = 4'd1,
  parameter logic [3:0]  REV_MINOR = 4'd0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_sel_i,
  input  logic               reg_we_i,
  input  logic [11:0]        reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  input  logic [NUM_SRC-1:0] src_i,
  output logic               irq_no,
  output logic               fiq_no
);
  localparam int NUM_BANK = NUM_SRC / WORD_W;
  localparam int IDX_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int NUM_CH   = 2;

  logic        wr;
  logic        in_bank, in_lvl;
  logic [11:0] lvl_off;
  logic [IDX_W-1:0] lvl_idx;
  bank_reg_e   sub;
  int          bsel;
  logic        soft_rst;
  logic        autoidle_q, prot_q, done_q;

  lvl_t                            lvl_q [NUM_SRC];
  logic [NUM_SRC-1:0][PRIO_W-1:0]  prio_vec;
  logic [NUM_SRC-1:0]              route_fiq;
  logic [NUM_SRC-1:0]              mask_flat, swt_flat, act, pend_irq, pend_fiq;
  logic [NUM_CH-1:0][IDX_W-1:0]    ch_num;
  logic [NUM_CH-1:0]               ch_valid;
  logic [NUM_CH-1:0][31:0]         act_word;

  // address decode
  assign wr       = reg_sel_i & reg_we_i;
  assign in_bank  = (reg_addr_i[11:7] == 5'b00001) && (int'(reg_addr_i[6:5]) < NUM_BANK);
  assign bsel     = int'(reg_addr_i[6:5]);
  assign sub      = bank_reg_e'(reg_addr_i[4:2]);
  assign lvl_off  = reg_addr_i - A_LVL_BASE;
  assign in_lvl   = (reg_addr_i >= A_LVL_BASE) && (int'(lvl_off[11:2]) < NUM_SRC);
  assign lvl_idx  = lvl_off[IDX_W+1:2];
  assign soft_rst = wr && (reg_addr_i == A_SYSCFG) && reg_wdata_i[1];

  logic unused_bits;
  assign unused_bits = ^{reg_addr_i[1:0], lvl_off[1:0]};

  // control words
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      autoidle_q <= 1'b0;
      prot_q     <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      done_q <= !soft_rst;
      if (soft_rst) begin
        autoidle_q <= 1'b0;
        prot_q     <= 1'b0;
      end else if (wr && reg_addr_i == A_SYSCFG) begin
        autoidle_q <= reg_wdata_i[0];
      end else if (wr && reg_addr_i == A_PROT) begin
        prot_q <= reg_wdata_i[0];
      end
    end
  end

  // per-source level words
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_SRC; i++) lvl_q[i] <= '0;
    end else if (soft_rst) begin
      for (int i = 0; i < NUM_SRC; i++) lvl_q[i] <= '0;
    end else if (wr && in_lvl) begin
      lvl_q[lvl_idx] <= '{prio: reg_wdata_i[7:2], fiq: reg_wdata_i[0]};
    end
  end

  for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
    assign prio_vec[n]  = lvl_q[n].prio;
    assign route_fiq[n] = lvl_q[n].fiq;
  end

  // banks
  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    logic hit;
    assign hit = wr && in_bank && (reg_addr_i[6:5] == 2'(b));
    pic_bank #(.W(WORD_W)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (soft_rst),
      .wr_mask_i (hit && sub == BR_MASK),
      .wr_mclr_i (hit && sub == BR_MCLR),
      .wr_mset_i (hit && sub == BR_MSET),
      .wr_sset_i (hit && sub == BR_SSET),
      .wr_sclr_i (hit && sub == BR_SCLR),
      .wdata_i   (reg_wdata_i),
      .mask_o    (mask_flat[b*WORD_W +: WORD_W]),
      .swt_o     (swt_flat[b*WORD_W +: WORD_W])
    );
  end

  assign act      = src_i | swt_flat;
  assign pend_irq = act & ~mask_flat & ~route_fiq;
  assign pend_fiq = act & ~mask_flat & route_fiq;
  assign irq_no   = ~|pend_irq;
  assign fiq_no   = ~|pend_fiq;

  // one capture channel per request line: 0 = IRQ, 1 = FIQ
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pic_channel #(.N(NUM_SRC), .PW(PRIO_W), .IW(IDX_W)) u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (soft_rst),
      .ack_i   (wr && reg_addr_i == A_CTRL && reg_wdata_i[c]),
      .pend_i  ((c == 0) ? pend_irq : pend_fiq),
      .prio_i  (prio_vec),
      .num_o   (ch_num[c]),
      .valid_o (ch_valid[c])
    );
    assign act_word[c] = ch_valid[c] ? {25'd0, 7'(ch_num[c])} : NONE_WORD;
  end

  // read mux
  always_comb begin
    reg_rdata_o = '0;
    if (in_bank) begin
      unique case (sub)
        BR_RAW:                    reg_rdata_o = act[bsel*WORD_W +: WORD_W];
        BR_MASK, BR_MCLR, BR_MSET: reg_rdata_o = mask_flat[bsel*WORD_W +: WORD_W];
        BR_SSET, BR_SCLR:          reg_rdata_o = swt_flat[bsel*WORD_W +: WORD_W];
        BR_PIRQ:                   reg_rdata_o = pend_irq[bsel*WORD_W +: WORD_W];
        BR_PFIQ:                   reg_rdata_o = pend_fiq[bsel*WORD_W +: WORD_W];
        default:                   reg_rdata_o = '0;
      endcase
    end else if (in_lvl) begin
      reg_rdata_o = {24'd0, lvl_q[lvl_idx].prio, 1'b0, lvl_q[lvl_idx].fiq};
    end else begin
      case (reg_addr_i)
        A_REV:     reg_rdata_o = {24'd0, REV_MAJOR, REV_MINOR};
        A_SYSCFG:  reg_rdata_o = {31'd0, autoidle_q};
        A_SYSSTAT: reg_rdata_o = {31'd0, done_q};
        A_ACT_IRQ: reg_rdata_o = act_word[0];
        A_ACT_FIQ: reg_rdata_o = act_word[1];
        A_PROT:    reg_rdata_o = {31'd0, prot_q};
        default:   reg_rdata_o = '0;
      endcase
    end
  end

  // R11
  soft_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst |=> !done_q);
  // R1
  done_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !soft_rst |=> done_q);
endmodule

// File: tb/tb_pic_top.sv
`timescale 1ns/1ps
module tb_pic_top;
  localparam int NS = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sel = 1'b0, we = 1'b0;
  logic [11:0]   addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NS-1:0] src = '0;
  logic          irq_n, fiq_n;

  int  n_chk = 0, n_bad = 0;
  bit  finished = 0;

  always #2.5 clk = ~clk;

  pic_top #(.NUM_SRC(NS)) dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_sel_i(sel), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .src_i(src), .irq_no(irq_n), .fiq_no(fiq_n)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic wr_src(input logic [11:0] a, input logic [31:0] d, input logic [NS-1:0] s);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d; src = s;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    sel = 1'b1; we = 1'b0; addr = a;
    #0.1;
    d = rdata;
    sel = 1'b0;
  endtask

  function automatic logic [5:0] prio_of(input int n);
    return 6'((n * 5 + 3) % 16);
  endfunction
  function automatic logic route_of(input int n);
    return (n % 3) == 0;
  endfunction
  function automatic logic [11:0] bank_a(input int b, input int off);
    return 12'(128 + 32 * b + off);
  endfunction
  function automatic logic [31:0] model(input logic [NS-1:0] s, input logic fiq);
    int best = 99;
    int win = -1;
    for (int n = 0; n < NS; n++)
      if (s[n] && route_of(n) == fiq && int'(prio_of(n)) < best) begin
        best = int'(prio_of(n));
        win = n;
      end
    return (win < 0) ? 32'h80 : 32'(win);
  endfunction
  function automatic logic [NS-1:0] pat(input int k);
    logic [31:0] a, b, c, d;
    a = 32'(k) * 32'h9E3779B1; b = 32'(k) * 32'h85EBCA6B;
    c = 32'(k) * 32'hC2B2AE35; d = 32'(k) * 32'h27D4EB2F;
    return {a & c, b ^ d};
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] ei, ef;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    for (int b = 0; b < NS / 32; b++) begin
      rd(bank_a(b, 4), v);    chk("R1 mask", v, 32'hFFFF_FFFF);
      rd(bank_a(b, 16), v);   chk("R1 trig", v, 0);
      rd(bank_a(b, 24), v);   chk("R1 pend", v, 0);
      tick();
    end
    for (int n = 0; n < NS; n++) begin
      rd(12'(256 + 4 * n), v); chk("R1 level", v, 0);
      if (n % 8 == 7) tick();
    end
    rd(12'h000, v); chk("R1 revision", v, 32'h10);
    rd(12'h014, v); chk("R1 ready", v, 1);
    rd(12'h040, v); chk("R1 active irq", v, 32'h80);
    chk("R1 irq_n", {31'd0, irq_n}, 1);
    chk("R1 fiq_n", {31'd0, fiq_n}, 1);

    // R12 stored bits
    wr(12'h04C, 1);            rd(12'h04C, v); chk("R12 prot set", v, 1);
    wr(12'h04C, 32'hFFFFFFFE); rd(12'h04C, v); chk("R12 prot clr", v, 0);
    wr(12'h010, 1);            rd(12'h010, v); chk("R12 autoidle", v, 1);

    // R13 read-only writes ignored
    wr(bank_a(0, 0), 32'hFFFF_FFFF);  rd(bank_a(0, 0), v);  chk("R13 raw", v, 0);
    wr(bank_a(1, 24), 32'hFFFF_FFFF); rd(bank_a(1, 24), v); chk("R13 pend", v, 0);
    wr(12'h000, 32'hFFFF_FFFF);       rd(12'h000, v);       chk("R13 revision", v, 32'h10);
    wr(12'h040, 32'h5);               rd(12'h040, v);       chk("R13 active", v, 32'h80);

    // R7 level format
    wr(12'(256 + 20), 32'hFFFF_FFFF); rd(12'(256 + 20), v); chk("R7 level fmt", v, 32'hFD);

    // R3 mask aliases
    wr(bank_a(1, 4), 32'h0000_FFFF);
    wr(bank_a(1, 12), 32'h00F0_0000); rd(bank_a(1, 4), v);  chk("R3 mask set", v, 32'h00F0_FFFF);
    wr(bank_a(1, 8), 32'h0000_000F);  rd(bank_a(1, 8), v);  chk("R3 mask clr", v, 32'h00F0_FFF0);

    // R11 soft reset
    wr(12'h010, 3);
    rd(12'h014, v);       chk("R11 ready low", v, 0);
    rd(12'h010, v);       chk("R11 cfg cleared", v, 0);
    rd(bank_a(1, 4), v);  chk("R11 mask restored", v, 32'hFFFF_FFFF);
    rd(12'(256 + 20), v); chk("R11 level cleared", v, 0);
    tick();
    rd(12'h014, v);       chk("R11 ready high", v, 1);

    // levels used for the rest of the run
    for (int n = 0; n < NS; n++)
      wr(12'(256 + 4 * n), {24'd0, prio_of(n), 1'b0, route_of(n)});

    // per-source sweep: R2 R4 R5 R6 R9 R10 R3
    for (int n = 0; n < NS; n++) begin
      logic [11:0] act_a;
      logic [31:0] bitv;
      int b;
      b = n / 32;
      bitv = 32'd1 << (n % 32);
      act_a = route_of(n) ? 12'h044 : 12'h040;
      wr(bank_a(b, 16), bitv);
      rd(bank_a(b, 0), v);  chk("R2 raw bit", v, bitv);
      rd(bank_a(b, 24), v); chk("R5 masked", v, 0);
      wr(bank_a(b, 8), bitv);
      rd(bank_a(b, route_of(n) ? 28 : 24), v); chk("R5 pending", v, bitv);
      chk("R6 irq_n", {31'd0, irq_n}, {31'd0, route_of(n)});
      chk("R6 fiq_n", {31'd0, fiq_n}, {31'd0, !route_of(n)});
      tick();
      rd(act_a, v); chk("R9 capture", v, 32'(n));
      wr(bank_a(b, 20), bitv);
      rd(act_a, v); chk("R9 hold after clear", v, 32'(n));
      chk("R4 trigger cleared", {30'd0, irq_n, fiq_n}, 3);
      wr(12'h048, route_of(n) ? 2 : 1);
      rd(act_a, v); chk("R10 rearmed", v, 32'h80);
      wr(bank_a(b, 12), bitv);
      rd(bank_a(b, 4), v); chk("R3 remask", v, 32'hFFFF_FFFF);
    end

    // arbitration sweep: R8
    wr(bank_a(0, 4), 0);
    wr(bank_a(1, 4), 0);
    for (int k = 0; k < 12; k++) begin
      src = pat(k);
      wr(12'h048, 3);
      tick();
      rd(12'h040, v); chk("R8 irq winner", v, model(pat(k), 1'b0));
      rd(12'h044, v); chk("R8 fiq winner", v, model(pat(k), 1'b1));
    end

    // hold while inputs change: R9
    ei = model(pat(11), 1'b0); if (ei == 32'h80) ei = model('1, 1'b0);
    ef = model(pat(11), 1'b1); if (ef == 32'h80) ef = model('1, 1'b1);
    src = '1;
    tick(); tick();
    rd(12'h040, v); chk("R9 irq held", v, ei);
    rd(12'h044, v); chk("R9 fiq held", v, ef);

    // ack in the same cycle as an input change: R10 R8
    wr_src(12'h048, 1, pat(5));
    tick();
    rd(12'h040, v); chk("R10 irq new pattern", v, model(pat(5), 1'b0));
    rd(12'h044, v); chk("R10 fiq untouched", v, ef);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule